// File: doc/BRIEF.md
# Snooping Bus Transaction Sequencer

This block is the bus-facing half of a snooping cache controller. The processor side hands it one pending bus command: a read miss, a read-for-ownership miss, or an ownership upgrade for a block already held shared. The sequencer raises its bus request and holds it until the arbiter grants. It then drives the address and command for one cycle and waits for the target to accept. For commands that carry a line, it counts the data beats. It reports completion to the processor side.

The bus is atomic, so other masters' transactions can only appear while this block is still waiting for its grant. The block keeps answering snoops during that wait. It flushes dirty lines, invalidates copies and reports sharing. This keeps a pending request from blocking the master that holds the bus. A snoop can kill the very block that a pending upgrade targets. In that case the local shared copy is gone, so the upgrade is rewritten in place into a read-for-ownership. A flag records that the rewrite happened.

A write is acknowledged to the processor as committed in the cycle its transaction owns the bus. Ownership gained by a transaction is kept until the processor reports that the pending write is done. Snoops that hit the held block in that window are answered with a stall instead of an invalidation.

Top module: `bus_txn_seq`

## Requirements
- R1: After reset, req_ready is 1 and bus_req, bus_addr_vld, commit_o, txn_done, cmd_converted and all snoop responses are 0, with bus_cmd 2'b00.
- R2: An accepted request (req_valid with req_cmd not 2'b00 while req_ready) raises bus_req on the next cycle and holds it until the cycle bus_gnt is sampled. The next cycle shows bus_addr_vld for exactly one cycle, with the pending command and address. The cycle after that shows neither bus_req nor bus_addr_vld.
- R3: After bus_ack is sampled, a read (2'b01) or read-for-ownership (2'b10) waits for BEATS sampled bus_beat pulses, and txn_done rises the cycle after the last one. An upgrade (2'b11) moves no data, and txn_done rises the cycle after bus_ack.
- R4: A snoop with command 2'b10 or 2'b11 may arrive while an upgrade waits for its grant. If its address matches the pending one in all bits above the OFFS_W offset bits, the pending command becomes 2'b10, cmd_converted becomes 1 the next cycle, and the transaction then moves BEATS data beats.
- R5: A snooped read (2'b01), or a snoop to a different block, leaves a pending upgrade unchanged: cmd_converted stays 0 and the bus shows 2'b11.
- R6: Snoops are serviced while bus_req is held. The cycle after a snooped read or read-for-ownership that hits a dirty line, snp_flush is 1 and bus_req stays 1.
- R7: The cycle after a snooped 2'b10 or 2'b11 that hits a valid line outside a held block, snp_inval is 1. The cycle after a snooped read that hits such a line, snp_shared is 1.
- R8: commit_o is 1 exactly in the address cycle of a 2'b10 or 2'b11 transaction and never for a read.
- R9: After a 2'b10 or 2'b11 transaction, txn_done stays 1 until proc_wr_done is sampled, and req_ready returns the cycle after. A snoop to that block from its address cycle until then gives snp_stall 1 and neither snp_inval nor snp_flush.
- R10: After a read transaction, txn_done lasts one cycle and req_ready returns the next cycle without proc_wr_done.
- R11: req_ready is 0 while a transaction is in flight, and req_valid at that time is ignored: the bus carries the first request's command and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor side presents a command |
| req_cmd | input | 2 | 01 read, 10 read-for-ownership, 11 upgrade |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Sequencer idle, request taken |
| commit_o | output | 1 | Write committed: ownership transaction holds the bus |
| txn_done | output | 1 | Transaction finished |
| proc_wr_done | input | 1 | Processor performed the write under held ownership |
| cmd_converted | output | 1 | Pending upgrade was rewritten to read-for-ownership |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_addr_vld | output | 1 | Address and command valid on bus |
| bus_cmd | output | 2 | Bus command, 00 when not driving |
| bus_addr | output | ADDR_W | Bus address, 0 when not driving |
| bus_ack | input | 1 | Target accepted the command |
| bus_beat | input | 1 | One data beat transferred |
| snp_valid | input | 1 | Another master's transaction observed |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | input | 1 | Tag array: snooped line is valid here |
| snp_dirty | input | 1 | Tag array: snooped line is dirty here |
| snp_flush | output | 1 | Supply dirty line |
| snp_inval | output | 1 | Invalidate local copy |
| snp_shared | output | 1 | Report shared copy |
| snp_stall | output | 1 | Block held under ownership, defer |

## Verification
The bench runs each of the three commands through a full bus tenure, with grant and acknowledge delays. A read shows the data phase and the immediate release. A read-for-ownership adds the commit pulse and the held-ownership window. An upgrade shows that the data phase is skipped. Pending upgrades are then hit with snoops that differ in one respect each: same block with an invalidating command, same block with a read, and a different block. This isolates the block match and command class that trigger the rewrite. Dirty and clean hits during the grant wait separate flush from share. A second request pushed mid-flight shows that the first one is not disturbed.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_UPGR = 2'b11
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_WAIT_ACK,
    ST_DATA,
    ST_DONE
  } seq_state_e;

  // command gains exclusive ownership
  function automatic logic wants_owner(input bus_cmd_e c);
    return (c == CMD_RDX) || (c == CMD_UPGR);
  endfunction

  // command transfers a line
  function automatic logic moves_data(input bus_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDX);
  endfunction

  // snooped command destroys other copies
  function automatic logic kills_copy(input bus_cmd_e c);
    return (c == CMD_RDX) || (c == CMD_UPGR);
  endfunction

  // snooped command needs dirty data supplied
  function automatic logic needs_flush(input bus_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDX);
  endfunction

endpackage

// File: rtl/bts_blk_cmp.sv
module bts_blk_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  output logic              same_blk
);
  logic [ADDR_W-1:0] diff;
  assign diff = a ^ b;

  generate
    if (OFFS_W == 0) begin : g_full
      assign same_blk = (diff == '0);
    end else begin : g_line
      assign same_blk = ((diff >> OFFS_W) == '0);
    end
  endgenerate
endmodule

// File: rtl/bts_beat_ctr.sv
module bts_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic beat,
  output logic last_beat
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (beat)      cnt <= cnt + 1'b1;
  end

  assign last_beat = run && beat && (cnt == LAST);
endmodule

// File: rtl/bts_snoop_resp.sv
module bts_snoop_resp
  import bts_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_valid,
  input  bus_cmd_e snp_cmd,
  input  logic     snp_hit,
  input  logic     snp_dirty,
  input  logic     held_match,
  output logic     snp_flush,
  output logic     snp_inval,
  output logic     snp_shared,
  output logic     snp_stall
);
  logic live_hit;
  assign live_hit = snp_valid && snp_hit && !held_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_flush  <= 1'b0;
      snp_inval  <= 1'b0;
      snp_shared <= 1'b0;
      snp_stall  <= 1'b0;
    end else begin
      snp_stall  <= snp_valid && held_match;
      snp_flush  <= live_hit && snp_dirty && needs_flush(snp_cmd);
      snp_inval  <= live_hit && kills_copy(snp_cmd);
      snp_shared <= live_hit && (snp_cmd == CMD_RD);
    end
  end
endmodule

// File: rtl/bts_seq_core.sv
module bts_seq_core
  import bts_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  bus_cmd_e          req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic              last_beat,
  input  logic              proc_wr_done,
  input  logic              kill_pending,
  output seq_state_e        state,
  output bus_cmd_e          pend_cmd,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              converted,
  output logic              accept_ev,
  output logic              convert_ev
);
  assign accept_ev  = (state == ST_IDLE) && req_valid && (req_cmd != CMD_NONE);
  assign convert_ev = (state == ST_REQ) && kill_pending && (pend_cmd == CMD_UPGR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_cmd  <= CMD_NONE;
      pend_addr <= '0;
      converted <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_ev) begin
            pend_cmd  <= req_cmd;
            pend_addr <= req_addr;
            converted <= 1'b0;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (convert_ev) begin
            pend_cmd  <= CMD_RDX;
            converted <= 1'b1;
          end
          if (bus_gnt) state <= ST_ADDR;
        end
        ST_ADDR: state <= ST_WAIT_ACK;
        ST_WAIT_ACK: begin
          if (bus_ack) state <= moves_data(pend_cmd) ? ST_DATA : ST_DONE;
        end
        ST_DATA: begin
          if (last_beat) state <= ST_DONE;
        end
        ST_DONE: begin
          if (!wants_owner(pend_cmd) || proc_wr_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_txn_seq.sv
module bus_txn_seq
  import bts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              commit_o,
  output logic              txn_done,
  input  logic              proc_wr_done,
  output logic              cmd_converted,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_addr_vld,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_beat,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_hit,
  input  logic              snp_dirty,
  output logic              snp_flush,
  output logic              snp_inval,
  output logic              snp_shared,
  output logic              snp_stall
);
  seq_state_e        state;
  bus_cmd_e          pend_cmd;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_match;
  logic              kill_pending;
  logic              held_match;
  logic              last_beat;
  logic              accept_ev;
  logic              convert_ev;
  logic              own_phase;
  bus_cmd_e          snp_cmd_e;
  bus_cmd_e          req_cmd_e;

  assign snp_cmd_e = bus_cmd_e'(snp_cmd);
  assign req_cmd_e = bus_cmd_e'(req_cmd);

  bts_blk_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_cmp (
    .a        (snp_addr),
    .b        (pend_addr),
    .same_blk (pend_match)
  );

  assign kill_pending = snp_valid && kills_copy(snp_cmd_e) && pend_match;

  assign own_phase = wants_owner(pend_cmd) &&
                     ((state == ST_ADDR) || (state == ST_WAIT_ACK) ||
                      (state == ST_DATA) || (state == ST_DONE));
  assign held_match = own_phase && pend_match;

  bts_seq_core #(.ADDR_W(ADDR_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cmd      (req_cmd_e),
    .req_addr     (req_addr),
    .bus_gnt      (bus_gnt),
    .bus_ack      (bus_ack),
    .last_beat    (last_beat),
    .proc_wr_done (proc_wr_done),
    .kill_pending (kill_pending),
    .state        (state),
    .pend_cmd     (pend_cmd),
    .pend_addr    (pend_addr),
    .converted    (cmd_converted),
    .accept_ev    (accept_ev),
    .convert_ev   (convert_ev)
  );

  bts_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == ST_DATA),
    .beat      (bus_beat),
    .last_beat (last_beat)
  );

  bts_snoop_resp u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd_e),
    .snp_hit    (snp_hit),
    .snp_dirty  (snp_dirty),
    .held_match (held_match),
    .snp_flush  (snp_flush),
    .snp_inval  (snp_inval),
    .snp_shared (snp_shared),
    .snp_stall  (snp_stall)
  );

  assign req_ready    = (state == ST_IDLE);
  assign bus_req      = (state == ST_REQ);
  assign bus_addr_vld = (state == ST_ADDR);
  assign bus_cmd      = bus_addr_vld ? pend_cmd : CMD_NONE;
  assign bus_addr     = bus_addr_vld ? pend_addr : '0;
  assign commit_o     = bus_addr_vld && wants_owner(pend_cmd);
  assign txn_done     = (state == ST_DONE);
endmodule

// File: rtl/bts_seq_chk.sv
module bts_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       commit_o,
  input logic       txn_done,
  input logic       cmd_converted,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_addr_vld,
  input logic [1:0] bus_cmd,
  input logic       snp_flush,
  input logic       snp_inval,
  input logic       snp_stall
);
  // R2: request held until granted
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  // R2: grant leads to a single address cycle
  assert_addr_after_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> bus_addr_vld);
  assert_addr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_vld |=> !bus_addr_vld && !bus_req);
  // R4: a converted transaction shows read-for-ownership on the bus
  assert_conv_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_vld && cmd_converted |-> bus_cmd == 2'b10);
  // R8: commit only in an ownership address cycle
  assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> bus_addr_vld && bus_cmd[1]);
  // R9: held block answers with stall only
  assert_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |-> !snp_inval && !snp_flush);
  // R11: idle excludes in-flight activity
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req && !bus_addr_vld && !txn_done);
endmodule

bind bus_txn_seq bts_seq_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .commit_o      (commit_o),
  .txn_done      (txn_done),
  .cmd_converted (cmd_converted),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_addr_vld  (bus_addr_vld),
  .bus_cmd       (bus_cmd),
  .snp_flush     (snp_flush),
  .snp_inval     (snp_inval),
  .snp_stall     (snp_stall)
);

// File: tb/bus_txn_seq_tb_top.sv
module bus_txn_seq_tb_top;
  localparam int AW = 32;
  localparam int BEATS = 4;
  localparam logic [1:0] RD = 2'b01, RDX = 2'b10, UPGR = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, proc_wr_done = 0, bus_gnt = 0, bus_ack = 0, bus_beat = 0;
  logic [1:0] req_cmd = 0, snp_cmd = 0;
  logic [AW-1:0] req_addr = 0, snp_addr = 0;
  logic snp_valid = 0, snp_hit = 0, snp_dirty = 0;
  logic req_ready, commit_o, txn_done, cmd_converted, bus_req, bus_addr_vld;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic snp_flush, snp_inval, snp_shared, snp_stall;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic          conv;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  bus_txn_seq #(.ADDR_W(AW), .OFFS_W(6), .BEATS(BEATS)) dut_i (.*);

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare at each address cycle
  always @(negedge clk) begin
    if (rst_n && bus_addr_vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected bus tenure", 64'(bus_cmd), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_cmd == e.cmd, "R2/R4/R5 bus_cmd", 64'(bus_cmd), 64'(e.cmd));
        check(bus_addr == e.addr, "R2/R11 bus_addr", 64'(bus_addr), 64'(e.addr));
        check(cmd_converted == e.conv, "R4/R5 cmd_converted", 64'(cmd_converted), 64'(e.conv));
        check(commit_o == e.cmd[1], "R8 commit_o", 64'(commit_o), 64'(e.cmd[1]));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] c, input logic [AW-1:0] a, input logic conv);
    exp_t e;
    e.cmd = conv ? RDX : c; e.addr = a; e.conv = conv;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(bus_req == 1'b1, "R2 bus_req raised", 64'(bus_req), 64'd1);
    check(req_ready == 1'b0, "R11 req_ready busy", 64'(req_ready), 64'd0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic hit, input logic dirty,
                       output logic fl, output logic inv, output logic sh, output logic st);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_hit = hit; snp_dirty = dirty;
    @(negedge clk);
    snp_valid = 0; snp_hit = 0; snp_dirty = 0;
    fl = snp_flush; inv = snp_inval; sh = snp_shared; st = snp_stall;
  endtask

  // from REQ: wait, grant, address, acknowledge, data, done, release
  task automatic run_bus(input int dly, input int beats, input logic owner, input logic [AW-1:0] a);
    logic fl, inv, sh, st;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(bus_req == 1'b1, "R2 bus_req held", 64'(bus_req), 64'd1);
    end
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    @(negedge clk);
    check(!bus_addr_vld && !bus_req, "R2 after address cycle", 64'({bus_addr_vld, bus_req}), 64'd0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(txn_done == 1'b0, "R3 waiting ack", 64'(txn_done), 64'd0);
    end
    bus_ack = 1;
    @(negedge clk);
    bus_ack = 0;
    if (beats == 0) begin
      check(txn_done == 1'b1, "R3 upgrade no data", 64'(txn_done), 64'd1);
    end else begin
      for (int b = 0; b < beats; b++) begin
        @(negedge clk);
        bus_beat = 0;
        check(txn_done == 1'b0, "R3 beats pending", 64'(txn_done), 64'd0);
        bus_beat = 1;
        @(negedge clk);
        bus_beat = 0;
      end
      check(txn_done == 1'b1, "R3 done after last beat", 64'(txn_done), 64'd1);
    end
    if (owner) begin
      @(negedge clk);
      check(txn_done == 1'b1, "R9 ownership held", 64'(txn_done), 64'd1);
      snoop(RDX, a + 8, 1'b1, 1'b1, fl, inv, sh, st);
      check(st && !inv && !fl, "R9 snoop to held block",
            64'({st, inv, fl}), 64'b100);
      proc_wr_done = 1;
      @(negedge clk);
      proc_wr_done = 0;
      check(req_ready == 1'b1, "R9 release after write", 64'(req_ready), 64'd1);
    end else begin
      @(negedge clk);
      check(req_ready == 1'b1 && txn_done == 1'b0, "R10 read releases",
            64'({req_ready, txn_done}), 64'b10);
    end
  endtask

  initial begin
    logic fl, inv, sh, st;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && !bus_req && !bus_addr_vld && !txn_done && !commit_o && !cmd_converted,
          "R1 reset outputs", 64'({req_ready, bus_req, bus_addr_vld, txn_done, commit_o, cmd_converted}),
          64'b100000);
    check(bus_cmd == 2'b00 && !snp_flush && !snp_inval && !snp_shared && !snp_stall,
          "R1 reset bus/snoop", 64'({bus_cmd, snp_flush, snp_inval, snp_shared, snp_stall}), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // plain read
    issue(RD, 32'h0000_1040, 1'b0);
    run_bus(2, BEATS, 1'b0, 32'h0000_1040);

    // read-for-ownership
    issue(RDX, 32'h0000_2080, 1'b0);
    run_bus(1, BEATS, 1'b1, 32'h0000_2080);

    // upgrade without interference
    issue(UPGR, 32'h0000_3000, 1'b0);
    run_bus(0, 0, 1'b1, 32'h0000_3000);

    // upgrade killed by a read-for-ownership to the same block: R4, R7
    issue(UPGR, 32'h0000_4100, 1'b1);
    snoop(RDX, 32'h0000_4124, 1'b1, 1'b0, fl, inv, sh, st);
    check(inv == 1'b1 && fl == 1'b0, "R7 invalidate on kill", 64'({inv, fl}), 64'b10);
    check(bus_req == 1'b1, "R6 still requesting", 64'(bus_req), 64'd1);
    check(cmd_converted == 1'b1, "R4 converted flag", 64'(cmd_converted), 64'd1);
    run_bus(1, BEATS, 1'b1, 32'h0000_4100);

    // upgrade with harmless snoops: R5, R6, R7
    issue(UPGR, 32'h0000_5000, 1'b0);
    snoop(RDX, 32'h0000_5040, 1'b0, 1'b0, fl, inv, sh, st);
    check(!inv && cmd_converted == 1'b0, "R5 other block no convert",
          64'({inv, cmd_converted}), 64'd0);
    snoop(RD, 32'h0000_5010, 1'b1, 1'b0, fl, inv, sh, st);
    check(sh && !fl && !inv, "R7 shared on read hit", 64'({sh, fl, inv}), 64'b100);
    check(cmd_converted == 1'b0, "R5 read snoop no convert", 64'(cmd_converted), 64'd0);
    snoop(RD, 32'h0000_6000, 1'b1, 1'b1, fl, inv, sh, st);
    check(fl == 1'b1 && bus_req == 1'b1, "R6 flush while waiting",
          64'({fl, bus_req}), 64'b11);
    run_bus(1, 0, 1'b1, 32'h0000_5000);

    // request during flight ignored: R11
    issue(RD, 32'h0000_7000, 1'b0);
    req_valid = 1; req_cmd = RDX; req_addr = 32'h0000_8000;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, "R11 busy while requesting", 64'(req_ready), 64'd0);
    run_bus(0, BEATS, 1'b0, 32'h0000_7000);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0 && req_ready, "R11 no extra tenure",
          64'(sb_q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule